// File: doc/BRIEF.md
# Vector Length Control Register

This block holds the privileged control word that sets the scalable vector length of a core. It sits behind the system-register access path. On each cycle it may receive one access: a 16-bit register selector, a read/write flag, 64 bits of write data, the current privilege level (0 to 3) and an enable bit taken from a separate trap-control register. One cycle after it accepts an access, it presents a response: a hit with read data, an undefined-access indication, or a trap with a 6-bit syndrome class.

Only a 4-bit length field is stored. The field asks for (field+1) x 128 bits, so from 128 up to 2048 bits. Reads return the field exactly as written. The `eff_len` output carries the length the datapath actually uses: the field rounded down to the nearest length that the `IMPL_MASK` parameter marks as implemented. Bit k of the mask stands for (k+1) x 128 bits, and bit 0 must be set.

The response logic is a small state machine. The state register loads a new value on every clock edge. The output process decodes that state into the response pins.

- `RSP_IDLE` is entered when there is no valid access or the selector does not match.
- `RSP_READ` is entered on a permitted read.
- `RSP_WRITE` is entered on a permitted write.
- `RSP_UNDEF` is entered on any access made below privilege level 3.
- `RSP_TRAP` is entered on a level-3 access while the enable bit is low.

Every state can move to any other state on the next edge, according to the access presented in that cycle.

Top module: `vlen_ctrl_reg`

## Requirements
- R1: The register answers only when `acc_valid` is 1 and `acc_sel` equals 16'hF090. This value is the packing {op0[15:14]=2'b11, op1[13:11]=3'b110, CRn[10:7]=4'b0001, CRm[6:3]=4'b0010, op2[2:0]=3'b000}. In every other case the next cycle shows `rsp_hit`, `rsp_undef` and `rsp_trap` all at 0, and the stored field is left unchanged.
- R2: A matching access at `acc_el` 0, 1 or 2 gives `rsp_hit`=1 and `rsp_undef`=1 with `rsp_trap`=0, whatever the value of `trap_en`. It never changes the stored field.
- R3: A matching access at `acc_el`=3 while `trap_en`=0 gives `rsp_hit`=1, `rsp_trap`=1, `rsp_class`=6'h19 and `rsp_undef`=0. It never changes the stored field.
- R4: A matching write at level 3 with `trap_en`=1 stores `acc_wdata[3:0]` and ignores `acc_wdata[63:4]`. Its response is `rsp_hit`=1 with no undef and no trap.
- R5: A matching read at level 3 with `trap_en`=1 returns `rsp_rdata` = {60'b0, stored field}. This is the raw value as written, not the rounded value.
- R6: `eff_len` equals the highest k at or below the stored field for which `IMPL_MASK[k]` is 1.
- R7: `eff_len` takes the new value on the same clock edge that accepts the write. A read accepted on the very next edge already returns the new field.
- R8: Each response lasts exactly one cycle after its accepting edge. While no response is presented, and out of reset, `rsp_hit`, `rsp_undef` and `rsp_trap` are 0, and `rsp_class` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_sel | input | 16 | Packed register selector |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| acc_el | input | 2 | Current privilege level |
| trap_en | input | 1 | Access enable bit from the trap-control register |
| rsp_hit | output | 1 | A response for this register is presented |
| rsp_undef | output | 1 | The access was undefined |
| rsp_trap | output | 1 | The access trapped to level 3 |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_rdata | output | 64 | Read data |
| eff_len | output | 4 | Effective length field after rounding down |

## Verification
All sixteen field values are written and read back under three masks: powers of two only, every length, and the smallest length alone. This separates the raw read path from the rounded path, and it exercises both ends of the round-down search. The write data carries junk in its upper bits, which shows that those bits are dropped. Accesses at each privilege level, with the enable bit both high and low, show that the privilege check has priority over the trap check. Single-bit corruptions of the selector, an access with `acc_valid` low, and a write followed directly by a read check the decode and the ordering of updates.

// File: rtl/vl_pkg.sv
package vl_pkg;
    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_READ,
        RSP_WRITE,
        RSP_UNDEF,
        RSP_TRAP
    } rsp_state_t;

    localparam logic [15:0] VL_SEL_CODE = 16'hF090;
    localparam logic [5:0]  VL_TRAP_EC  = 6'h19;
    localparam logic [1:0]  VL_TOP_EL   = 2'd3;
endpackage

// File: rtl/vl_access_decode.sv
module vl_access_decode
    import vl_pkg::*;
(
    input  logic        acc_valid,
    input  logic [15:0] acc_sel,
    input  logic        acc_write,
    input  logic [1:0]  acc_el,
    input  logic        trap_en,
    output rsp_state_t  next_state,
    output logic        wr_en
);
    logic sel_match;

    assign sel_match = acc_valid && (acc_sel == VL_SEL_CODE);

    // Privilege check first, then the trap enable.
    always_comb begin
        next_state = RSP_IDLE;
        if (sel_match) begin
            if (acc_el != VL_TOP_EL)
                next_state = RSP_UNDEF;
            else if (!trap_en)
                next_state = RSP_TRAP;
            else if (acc_write)
                next_state = RSP_WRITE;
            else
                next_state = RSP_READ;
        end
    end

    assign wr_en = (next_state == RSP_WRITE);
endmodule

// File: rtl/vl_len_store.sv
module vl_len_store #(
    parameter int LEN_W = 4,
    parameter logic [LEN_W-1:0] LEN_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] len_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= LEN_RST;
        else if (wr_en)
            len_q <= wr_len;
    end
endmodule

// File: rtl/vl_len_round.sv
module vl_len_round #(
    parameter int LEN_W = 4,
    parameter int NUM_LEN = 1 << LEN_W,
    parameter logic [NUM_LEN-1:0] IMPL_MASK = '1
) (
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] eff_out
);
    logic [NUM_LEN-1:0] avail;

    for (genvar k = 0; k < NUM_LEN; k++) begin : g_avail
        assign avail[k] = IMPL_MASK[k] && (len_in >= LEN_W'(k));
    end

    // Ascending scan: the last candidate found is the highest one.
    always_comb begin
        eff_out = '0;
        for (int k = 0; k < NUM_LEN; k++) begin
            if (avail[k])
                eff_out = LEN_W'(k);
        end
    end
endmodule

// File: rtl/vlen_ctrl_reg.sv
module vlen_ctrl_reg
    import vl_pkg::*;
#(
    parameter int REG_W = 64,
    parameter int LEN_W = 4,
    parameter int NUM_LEN = 1 << LEN_W,
    parameter logic [NUM_LEN-1:0] IMPL_MASK = 16'h808B,
    parameter logic [LEN_W-1:0] LEN_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [15:0]      acc_sel,
    input  logic             acc_write,
    input  logic [REG_W-1:0] acc_wdata,
    input  logic [1:0]       acc_el,
    input  logic             trap_en,
    output logic             rsp_hit,
    output logic             rsp_undef,
    output logic             rsp_trap,
    output logic [5:0]       rsp_class,
    output logic [REG_W-1:0] rsp_rdata,
    output logic [LEN_W-1:0] eff_len
);
    localparam int PAD_W = REG_W - LEN_W;

    rsp_state_t       state_q, state_d;
    logic             wr_en;
    logic [LEN_W-1:0] len_q;
    logic [REG_W-1:0] rdata_q;
    logic             wdata_hi_unused;

    assign wdata_hi_unused = ^acc_wdata[REG_W-1:LEN_W];

    vl_access_decode u_dec (
        .acc_valid  (acc_valid),
        .acc_sel    (acc_sel),
        .acc_write  (acc_write),
        .acc_el     (acc_el),
        .trap_en    (trap_en),
        .next_state (state_d),
        .wr_en      (wr_en)
    );

    vl_len_store #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_len (acc_wdata[LEN_W-1:0]),
        .len_q  (len_q)
    );

    vl_len_round #(.LEN_W(LEN_W), .NUM_LEN(NUM_LEN), .IMPL_MASK(IMPL_MASK)) u_round (
        .len_in  (len_q),
        .eff_out (eff_len)
    );

    // State register, with the raw read value captured alongside it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == RSP_READ) ? {{PAD_W{1'b0}}, len_q} : '0;
        end
    end

    // Output decode.
    always_comb begin
        rsp_hit   = 1'b0;
        rsp_undef = 1'b0;
        rsp_trap  = 1'b0;
        rsp_class = '0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_READ: begin
                rsp_hit   = 1'b1;
                rsp_rdata = rdata_q;
            end
            RSP_WRITE: rsp_hit = 1'b1;
            RSP_UNDEF: begin
                rsp_hit   = 1'b1;
                rsp_undef = 1'b1;
            end
            RSP_TRAP: begin
                rsp_hit   = 1'b1;
                rsp_trap  = 1'b1;
                rsp_class = VL_TRAP_EC;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk
    import vl_pkg::*;
#(
    parameter int REG_W = 64,
    parameter int LEN_W = 4,
    parameter int NUM_LEN = 1 << LEN_W,
    parameter logic [NUM_LEN-1:0] IMPL_MASK = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [15:0]      acc_sel,
    input logic             acc_write,
    input logic [1:0]       acc_el,
    input logic             trap_en,
    input logic             rsp_hit,
    input logic             rsp_undef,
    input logic             rsp_trap,
    input logic [5:0]       rsp_class,
    input logic [REG_W-1:0] rsp_rdata,
    input logic [LEN_W-1:0] eff_len,
    input logic [LEN_W-1:0] len_q
);
    logic matched;
    assign matched = acc_valid && (acc_sel == VL_SEL_CODE);

    AST_NO_RSP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !matched |=> (!rsp_hit && !rsp_undef && !rsp_trap)); // R1

    AST_LOW_EL_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (matched && acc_el != VL_TOP_EL) |=> (rsp_undef && !rsp_trap && $stable(len_q))); // R2

    AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (matched && acc_el == VL_TOP_EL && !trap_en) |=> (rsp_trap && rsp_class == VL_TRAP_EC && $stable(len_q))); // R3

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_undef, rsp_trap}) <= 1); // R8

    AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[REG_W-1:LEN_W] == '0); // R5

    AST_EFF_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (IMPL_MASK[eff_len] && eff_len <= len_q)); // R6

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(matched && acc_write) |=> $stable(eff_len)); // R7

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!matched && rsp_hit) |=> !rsp_hit); // R8
endmodule

bind vlen_ctrl_reg vlen_ctrl_chk #(
    .REG_W(REG_W), .LEN_W(LEN_W), .NUM_LEN(NUM_LEN), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_sel   (acc_sel),
    .acc_write (acc_write),
    .acc_el    (acc_el),
    .trap_en   (trap_en),
    .rsp_hit   (rsp_hit),
    .rsp_undef (rsp_undef),
    .rsp_trap  (rsp_trap),
    .rsp_class (rsp_class),
    .rsp_rdata (rsp_rdata),
    .eff_len   (eff_len),
    .len_q     (len_q)
);

// File: tb/sim_vlen_ctrl_reg.sv
`timescale 1ns/1ps
module sim_vlen_ctrl_reg;
    localparam logic [15:0] SEL    = 16'hF090;
    localparam logic [15:0] MASK_A = 16'h808B;
    localparam logic [15:0] MASK_B = 16'hFFFF;
    localparam logic [15:0] MASK_C = 16'h0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [15:0] acc_sel = '0;
    logic acc_write = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [1:0] acc_el = '0;
    logic trap_en = 1'b0;

    logic hit0, und0, trp0, hit1, und1, trp1, hit2, und2, trp2;
    logic [5:0] cls0, cls1, cls2;
    logic [63:0] rd0, rd1, rd2;
    logic [3:0] eff0, eff1, eff2;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vlen_ctrl_reg #(.IMPL_MASK(MASK_A)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_el(acc_el), .trap_en(trap_en),
        .rsp_hit(hit0), .rsp_undef(und0), .rsp_trap(trp0), .rsp_class(cls0),
        .rsp_rdata(rd0), .eff_len(eff0));
    vlen_ctrl_reg #(.IMPL_MASK(MASK_B)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_el(acc_el), .trap_en(trap_en),
        .rsp_hit(hit1), .rsp_undef(und1), .rsp_trap(trp1), .rsp_class(cls1),
        .rsp_rdata(rd1), .eff_len(eff1));
    vlen_ctrl_reg #(.IMPL_MASK(MASK_C)) u2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_el(acc_el), .trap_en(trap_en),
        .rsp_hit(hit2), .rsp_undef(und2), .rsp_trap(trp2), .rsp_class(cls2),
        .rsp_rdata(rd2), .eff_len(eff2));

    function automatic logic [3:0] round_down(input logic [15:0] m, input logic [3:0] l);
        for (int k = 15; k >= 0; k--)
            if (k <= int'(l) && m[k]) return 4'(k);
        return 4'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access: accepted on the next posedge, response sampled at the following negedge.
    task automatic access(input logic [15:0] sel, input logic wr, input logic [63:0] wd,
                          input logic [1:0] el, input logic ten, input logic vld);
        @(negedge clk);
        acc_valid = vld; acc_sel = sel; acc_write = wr; acc_wdata = wd;
        acc_el = el; trap_en = ten;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic check_len(input logic [3:0] l, input string req);
        access(SEL, 1'b0, 64'h0, 2'd3, 1'b1, 1'b1);
        check(hit0 && !und0 && !trp0 && rd0 == {60'b0, l}, req, rd0, {60'b0, l});
    endtask

    task automatic check_silent(input string req);
        check(!hit0 && !und0 && !trp0 && !hit1 && !hit2, req,
              {61'b0, hit0, und0, trp0}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!hit0 && !und0 && !trp0 && cls0 == 0 && rd0 == 0, "R8 reset",
              {58'b0, cls0}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6: sweep every field value, junk in the upper write bits
        for (int l = 0; l < 16; l++) begin
            access(SEL, 1'b1, {60'hA5A5_5A5A_F0F0_C3C, 4'(l)}, 2'd3, 1'b1, 1'b1);
            check(hit0 && !und0 && !trp0 && rd0 == 0, "R4 write response",
                  {61'b0, hit0, und0, trp0}, 64'h4);
            check(eff0 == round_down(MASK_A, 4'(l)), "R6 mask A", 64'(eff0), 64'(round_down(MASK_A, 4'(l))));
            check(eff1 == round_down(MASK_B, 4'(l)), "R6 mask B", 64'(eff1), 64'(round_down(MASK_B, 4'(l))));
            check(eff2 == round_down(MASK_C, 4'(l)), "R6 mask C", 64'(eff2), 64'(round_down(MASK_C, 4'(l))));
            check_len(4'(l), "R5 raw read");
            check(rd1 == 64'(l) && rd2 == 64'(l), "R5 raw read other masks", rd2, 64'(l));
            @(negedge clk);
            check_silent("R8 one-cycle response");
        end

        // R7: write then read on the next edge
        @(negedge clk);
        acc_valid = 1'b1; acc_sel = SEL; acc_write = 1'b1; acc_wdata = 64'h6;
        acc_el = 2'd3; trap_en = 1'b1;
        @(negedge clk);
        check(eff0 == 4'd3 && eff1 == 4'd6, "R7 eff at write edge", 64'(eff0), 64'd3);
        acc_write = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
        check(rd0 == 64'd6, "R7 read right after write", rd0, 64'd6);

        // R2: low privilege, trap enable high and low
        for (int el = 0; el < 3; el++) begin
            for (int te = 0; te < 2; te++) begin
                access(SEL, 1'b1, 64'h9, 2'(el), 1'(te), 1'b1);
                check(hit0 && und0 && !trp0 && rd0 == 0, "R2 undef", {61'b0, hit0, und0, trp0}, 64'h6);
                access(SEL, 1'b0, 64'h0, 2'(el), 1'(te), 1'b1);
                check(hit0 && und0 && !trp0 && rd0 == 0, "R2 undef read", {61'b0, hit0, und0, trp0}, 64'h6);
            end
        end
        check_len(4'd6, "R2 field unchanged");

        // R3: level 3 with enable low
        access(SEL, 1'b1, 64'h2, 2'd3, 1'b0, 1'b1);
        check(hit0 && trp0 && !und0 && cls0 == 6'h19, "R3 trap write", 64'(cls0), 64'h19);
        access(SEL, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1);
        check(trp0 && cls0 == 6'h19 && rd0 == 0, "R3 trap read", 64'(cls0), 64'h19);
        check_len(4'd6, "R3 field unchanged");
        check(eff0 == 4'd3, "R3 eff unchanged", 64'(eff0), 64'd3);

        // R1: single-bit selector corruption and valid low
        for (int b = 0; b < 16; b++) begin
            access(SEL ^ (16'h1 << b), 1'b1, 64'hF, 2'd3, 1'b1, 1'b1);
            check_silent("R1 selector mismatch");
        end
        access(SEL, 1'b1, 64'hF, 2'd3, 1'b1, 1'b0);
        check_silent("R1 valid low");
        check(eff1 == 4'd6, "R1 eff unchanged", 64'(eff1), 64'd6);
        check_len(4'd6, "R1 field unchanged");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule